// File: doc/BRIEF.md
# Depthwise vector-vector MAC threshold unit

This block is the compute engine of a streaming depthwise convolution. For every output pixel it receives, over several beats, the kernel-window activations of all channels. It multiplies them tap by tap with per-channel weights held in an internal read-only memory and accumulates one dot product per channel. Each sum either leaves the block as a raw signed value, or it passes through a multi-level threshold activation first.

Two parameters set the parallelism. `PE` lanes work on channels at once, and `SIMD` lanes work on kernel taps at once. A pixel therefore takes `(KH*KW/SIMD)*(CH/PE)` input beats, and each group of `PE` channels produces one output word when its last tap beat has been taken in. In the bipolar variant, operands coded as bits (bit 1 = +1, bit 0 = -1) are combined by XNOR and counted. The stored thresholds are pre-biased so that they compare directly against that count. A configuration is rejected at elaboration when `CH` is not a multiple of `PE` or when `KH*KW` is not a multiple of `SIMD`. Both streams use a valid/ready handshake.

Top module: `dw_vvmac`

## Requirements
- R1: After a synchronous reset, out_valid is 0 and in_ready is 1.
- R2: Input element (p,s) of a beat sits at bits [(p*SIMD+s)*IN_W +: IN_W]. Beat number n*SF+f of a pixel (SF=KH*KW/SIMD) carries tap f*SIMD+s of channel n*PE+p. In signed mode, channel c tap t has weight ((5c+3t) mod 7)-3. With thresholds off, lane p of the output (bits [p*ACC_W +: ACC_W]) is the signed sum of activation times weight.
- R3: A pixel yields CH/PE output words in order n = 0,1,..., and lane p of word n is channel n*PE+p.
- R4: Each channel's accumulation starts from zero, so back-to-back pixels do not influence each other.
- R5: With in_valid held high and out_ready high, a beat is taken every cycle. An output word becomes valid one cycle after the clock edge that accepts the last beat of its fold.
- R6: While out_valid=1 and out_ready=0, out_data stays stable, in_ready is 0, and no beat or result is lost.
- R7: With thresholds on, channel c has 2^OUT_B-1 thresholds 12j+4c (j=0,1,...). A sum meets a threshold when it is greater than or equal to it. A signed output is (number met) - 2^(OUT_B-1), in OUT_B bits per lane.
- R8: A threshold of exactly zero (channel 0, j=0) is met by a sum of zero.
- R9: In bipolar mode, channel c tap t has weight bit 1 exactly when (c+2t) mod 3 = 0. The stored threshold is ceil((T+KH*KW)/2), with true threshold T=2c-3. The binary output bit is 1 exactly when the true +/-1 dot product is at least T.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Block can take a beat this cycle |
| in_data | input | PE*SIMD*IN_W | SIMD taps for each of PE channels |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream takes the output word |
| out_data | output | PE*OW | One result per PE lane (OW = OUT_B with thresholds, else ACC_W) |

## Verification
A beat is taken at the rising edge where in_valid and in_ready are both high. The weights and thresholds are read in that same edge. The output register loads at the next edge, so a fold's result is visible one cycle after its last beat is accepted, and it holds until the downstream takes it. The bench changes inputs and out_ready on the falling edge and reads ports 1 to 2 ns later. It checks out_valid at the falling edge right after the last beat is accepted (still low) and at the one after that (high). Each returned word is compared against a queue of sums and threshold levels computed arithmetically, which also confirms ordering and that nothing is dropped under backpressure.

// File: rtl/dw_vvmac_pkg.sv
package dw_vvmac_pkg;

  // Weight of channel ch at kernel tap tap (bipolar: bit, 1 means +1).
  function automatic int wgt_val(bit bip, int ch, int tap);
    if (bip) return (((ch + 2 * tap) % 3) == 0) ? 1 : 0;
    return ((ch * 5 + tap * 3) % 7) - 3;
  endfunction

  // Threshold level lvl of channel ch; bipolar values are biased to popcount.
  function automatic int thr_val(bit bip, int ch, int lvl, int taps);
    if (bip) return (2 * ch - 3 + 4 * lvl + taps + 1) / 2;
    return 12 * lvl + 4 * ch;
  endfunction

endpackage

// File: rtl/dw_vvmac_wrom.sv
module dw_vvmac_wrom
  import dw_vvmac_pkg::*;
#(
  parameter int PE      = 2,
  parameter int SIMD    = 3,
  parameter int W_W     = 4,
  parameter int SF      = 3,
  parameter int NF      = 2,
  parameter bit BIPOLAR = 0,
  parameter int AW      = 3,
  localparam int DEPTH  = SF * NF,
  localparam int WW     = PE * SIMD * W_W
) (
  input  logic          clk,
  input  logic          en,
  input  logic [AW-1:0] addr,
  output logic [WW-1:0] rdata
);

  logic [WW-1:0] mem [DEPTH];

  initial begin
    for (int a = 0; a < DEPTH; a++) begin
      for (int p = 0; p < PE; p++) begin
        for (int s = 0; s < SIMD; s++) begin
          mem[a][(p*SIMD+s)*W_W +: W_W] =
            W_W'(wgt_val(BIPOLAR, (a / SF) * PE + p, (a % SF) * SIMD + s));
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (en) rdata <= mem[addr];
  end

endmodule

// File: rtl/dw_vvmac_trom.sv
module dw_vvmac_trom
  import dw_vvmac_pkg::*;
#(
  parameter int PE      = 2,
  parameter int NT      = 3,
  parameter int ACC_W   = 16,
  parameter int NF      = 2,
  parameter int TAPS    = 9,
  parameter bit BIPOLAR = 0,
  parameter int AW      = 1,
  localparam int WW     = PE * NT * ACC_W
) (
  input  logic          clk,
  input  logic          en,
  input  logic [AW-1:0] addr,
  output logic [WW-1:0] rdata
);

  logic [WW-1:0] mem [NF];

  initial begin
    for (int a = 0; a < NF; a++) begin
      for (int p = 0; p < PE; p++) begin
        for (int j = 0; j < NT; j++) begin
          mem[a][(p*NT+j)*ACC_W +: ACC_W] =
            ACC_W'(thr_val(BIPOLAR, a * PE + p, j, TAPS));
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (en) rdata <= mem[addr];
  end

endmodule

// File: rtl/dw_vvmac_lane.sv
module dw_vvmac_lane #(
  parameter int SIMD    = 3,
  parameter int IN_W    = 4,
  parameter int W_W     = 4,
  parameter int ACC_W   = 16,
  parameter bit BIPOLAR = 0
) (
  input  logic [SIMD*IN_W-1:0]    acts,
  input  logic [SIMD*W_W-1:0]     wgts,
  output logic signed [ACC_W-1:0] psum
);

  logic signed [ACC_W-1:0] term [SIMD];

  for (genvar s = 0; s < SIMD; s++) begin : g_tap
    if (BIPOLAR) begin : g_xnor
      assign term[s] = {{(ACC_W-1){1'b0}}, acts[s*IN_W] ~^ wgts[s*W_W]};
    end else begin : g_mul
      assign term[s] = ACC_W'($signed(acts[s*IN_W +: IN_W]) *
                              $signed(wgts[s*W_W +: W_W]));
    end
  end

  always_comb begin
    psum = {ACC_W{1'b0}};
    for (int s = 0; s < SIMD; s++) psum = psum + term[s];
  end

endmodule

// File: rtl/dw_vvmac_thr.sv
module dw_vvmac_thr #(
  parameter int NT      = 3,
  parameter int ACC_W   = 16,
  parameter int OUT_B   = 2,
  parameter bit BIN_OUT = 0
) (
  input  logic signed [ACC_W-1:0] sum,
  input  logic [NT*ACC_W-1:0]     thr,
  output logic [OUT_B-1:0]        level
);

  logic [OUT_B-1:0] cnt;

  always_comb begin
    cnt = '0;
    for (int j = 0; j < NT; j++) begin
      if (sum >= $signed(thr[j*ACC_W +: ACC_W])) cnt = cnt + OUT_B'(1);
    end
    if (BIN_OUT) level = cnt;
    else         level = cnt - (OUT_B'(1) << (OUT_B - 1));
  end

endmodule

// File: rtl/dw_vvmac.sv
module dw_vvmac #(
  parameter int CH        = 4,
  parameter int PE        = 2,
  parameter int KH        = 3,
  parameter int KW        = 3,
  parameter int SIMD      = 3,
  parameter int IN_W      = 4,
  parameter int W_W       = 4,
  parameter int ACC_W     = 16,
  parameter int OUT_B     = 2,
  parameter bit THRESH_EN = 1,
  parameter bit BIPOLAR   = 0,
  parameter bit BIN_OUT   = 0,
  localparam int OW       = THRESH_EN ? OUT_B : ACC_W
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [PE*SIMD*IN_W-1:0] in_data,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [PE*OW-1:0]       out_data
);

  localparam int K     = KH * KW;
  localparam int SF    = K / SIMD;
  localparam int NF    = CH / PE;
  localparam int NT    = (1 << OUT_B) - 1;
  localparam int DEPTH = SF * NF;
  localparam int SFW   = (SF > 1) ? $clog2(SF) : 1;
  localparam int NFW   = (NF > 1) ? $clog2(NF) : 1;
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  if ((CH % PE) != 0 || (K % SIMD) != 0) begin : g_bad_cfg
    $error("dw_vvmac: CH must divide by PE and KH*KW by SIMD");
  end

  // Handshake: the whole pipe moves only when the output slot is free.
  logic advance, accept;
  assign advance  = !out_valid || out_ready;
  assign in_ready = advance;
  assign accept   = in_valid && advance;

  // Fold counters: tap fold inner, channel fold outer.
  logic [SFW-1:0] sf_q;
  logic [NFW-1:0] nf_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sf_q <= '0;
      nf_q <= '0;
    end else if (accept) begin
      if (sf_q == SFW'(SF - 1)) begin
        sf_q <= '0;
        nf_q <= (nf_q == NFW'(NF - 1)) ? '0 : nf_q + NFW'(1);
      end else begin
        sf_q <= sf_q + SFW'(1);
      end
    end
  end

  // Stage 1: capture beat, read weight and threshold words.
  logic                     s1_valid, s1_first, s1_last;
  logic [PE*SIMD*IN_W-1:0]  s1_data;
  logic [PE*SIMD*W_W-1:0]   wrom_q;
  logic [PE*NT*ACC_W-1:0]   trom_q;
  logic [AW-1:0]            waddr;

  assign waddr = AW'(int'(nf_q) * SF + int'(sf_q));

  dw_vvmac_wrom #(
    .PE(PE), .SIMD(SIMD), .W_W(W_W), .SF(SF), .NF(NF),
    .BIPOLAR(BIPOLAR), .AW(AW)
  ) u_wrom (
    .clk(clk), .en(advance), .addr(waddr), .rdata(wrom_q)
  );

  if (THRESH_EN) begin : g_trom
    dw_vvmac_trom #(
      .PE(PE), .NT(NT), .ACC_W(ACC_W), .NF(NF), .TAPS(K),
      .BIPOLAR(BIPOLAR), .AW(NFW)
    ) u_trom (
      .clk(clk), .en(advance), .addr(nf_q), .rdata(trom_q)
    );
  end else begin : g_no_trom
    assign trom_q = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
    end else if (advance) begin
      s1_valid <= in_valid;
    end
    if (advance) begin
      s1_data  <= in_data;
      s1_first <= (sf_q == '0);
      s1_last  <= (sf_q == SFW'(SF - 1));
    end
  end

  // Stage 2: per-lane tree, accumulate, optional threshold.
  logic [OW-1:0] res [PE];

  for (genvar p = 0; p < PE; p++) begin : g_pe
    logic signed [ACC_W-1:0] lane_sum, acc_q, acc_nxt;

    dw_vvmac_lane #(
      .SIMD(SIMD), .IN_W(IN_W), .W_W(W_W), .ACC_W(ACC_W), .BIPOLAR(BIPOLAR)
    ) u_lane (
      .acts(s1_data[p*SIMD*IN_W +: SIMD*IN_W]),
      .wgts(wrom_q[p*SIMD*W_W +: SIMD*W_W]),
      .psum(lane_sum)
    );

    assign acc_nxt = (s1_first ? {ACC_W{1'b0}} : acc_q) + lane_sum;

    always_ff @(posedge clk) begin
      if (advance && s1_valid) acc_q <= acc_nxt;
    end

    if (THRESH_EN) begin : g_act
      dw_vvmac_thr #(
        .NT(NT), .ACC_W(ACC_W), .OUT_B(OUT_B), .BIN_OUT(BIN_OUT)
      ) u_thr (
        .sum(acc_nxt), .thr(trom_q[p*NT*ACC_W +: NT*ACC_W]), .level(res[p])
      );
    end else begin : g_raw
      assign res[p] = acc_nxt;
    end
  end

  // Registered output.
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
    end else if (advance) begin
      out_valid <= s1_valid && s1_last;
    end
    if (advance && s1_valid && s1_last) begin
      for (int p = 0; p < PE; p++) out_data[p*OW +: OW] <= res[p];
    end
  end

endmodule

// File: rtl/dw_vvmac_chk.sv
module dw_vvmac_chk #(
  parameter int DW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [DW-1:0] out_data
);

  // R1
  rst_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !out_valid);

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R6
  only_taken_drop_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(out_valid) |-> $past(out_ready));

  // R5
  result_latency_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> $past(in_valid && in_ready, 2));

endmodule

bind dw_vvmac dw_vvmac_chk #(.DW(PE*OW)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
);

// File: tb/dw_vvmac_bench.sv
module dw_vvmac_bench;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  // Signed instances (threshold and raw) share one input stream.
  logic        s_v = 1'b0;
  logic [23:0] s_d = '0;
  logic        a_rdy, b_rdy, a_ov, b_ov;
  logic [3:0]  a_od;
  logic [31:0] b_od;
  // Bipolar instance.
  logic        c_v = 1'b0;
  logic [5:0]  c_d = '0;
  logic        c_rdy, c_ov;
  logic [1:0]  c_od;
  logic        out_ready = 1'b1;

  dw_vvmac u_dw_vvmac (
    .clk(clk), .rst(rst), .in_valid(s_v), .in_ready(a_rdy), .in_data(s_d),
    .out_valid(a_ov), .out_ready(out_ready), .out_data(a_od));

  dw_vvmac #(.THRESH_EN(0)) u_raw (
    .clk(clk), .rst(rst), .in_valid(s_v), .in_ready(b_rdy), .in_data(s_d),
    .out_valid(b_ov), .out_ready(out_ready), .out_data(b_od));

  dw_vvmac #(.IN_W(1), .W_W(1), .ACC_W(8), .OUT_B(1), .BIPOLAR(1), .BIN_OUT(1)) u_bip (
    .clk(clk), .rst(rst), .in_valid(c_v), .in_ready(c_rdy), .in_data(c_d),
    .out_valid(c_ov), .out_ready(out_ready), .out_data(c_od));

  int checks = 0, failures = 0, cyc = 0;
  bit done = 0, bp = 0, held = 0;
  string a_tag = "R7", b_tag = "R2", c_tag = "R9";
  logic [3:0]  qa [$];
  logic [31:0] qb [$];
  logic [1:0]  qc [$];
  logic [31:0] hold_b;
  time t_first, t_last;

  task automatic chk(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int sw(int c, int t); return ((c*5 + t*3) % 7) - 3; endfunction
  function automatic int bwb(int c, int t); return (((c + 2*t) % 3) == 0) ? 1 : 0; endfunction
  function automatic int act_s(int pat, int pix, int c, int t);
    case (pat)
      0: return 0;
      1: return 7;
      2: return -8;
      default: return (((pix*37 + c*11 + t*7) * 13) % 16) - 8;
    endcase
  endfunction
  function automatic int act_b(int pix, int c, int t);
    return ((((pix*5 + c*3 + t) * 7) % 5) < 2) ? 1 : 0;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      failures++;
      $display("FAIL R5 watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  always @(negedge clk) out_ready <= bp ? ((cyc % 3) != 0) : 1'b1;

  // Output monitor: compares each taken word with its queued expectation.
  always @(negedge clk) begin
    #2;
    if (!rst && a_ov && out_ready) begin
      if (qa.size() == 0) chk(0, a_tag, a_od, -1);
      else begin logic [3:0] e; e = qa.pop_front(); chk(a_od == e, a_tag, a_od, e); end
    end
    if (!rst && b_ov && out_ready) begin
      if (qb.size() == 0) chk(0, b_tag, b_od, -1);
      else begin logic [31:0] e; e = qb.pop_front(); chk(b_od == e, b_tag, b_od, e); end
    end
    if (!rst && c_ov && out_ready) begin
      if (qc.size() == 0) chk(0, c_tag, c_od, -1);
      else begin logic [1:0] e; e = qc.pop_front(); chk(c_od == e, c_tag, c_od, e); end
    end
    if (!rst && b_ov && !out_ready) begin
      // R6: stalled word stays put and no new beat is taken
      if (held) chk(b_od == hold_b && !a_rdy, "R6", b_od, hold_b);
      hold_b = b_od;
      held = 1;
    end else held = 0;
  end

  task automatic send_beat(bit bip, logic [23:0] d);
    @(negedge clk);
    if (bip) begin c_v = 1'b1; c_d = d[5:0]; end
    else begin s_v = 1'b1; s_d = d; end
    #1;
    while (!(bip ? c_rdy : a_rdy)) begin @(negedge clk); #1; end
    @(posedge clk);
    t_last = $time;
  endtask

  task automatic idle(int n);
    @(negedge clk);
    s_v = 1'b0;
    c_v = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic pixel_s(int pat, int pix);
    for (int n = 0; n < 2; n++) begin
      logic [3:0] ea;
      logic [31:0] eb;
      for (int p = 0; p < 2; p++) begin
        int c, sum, cnt;
        c = n*2 + p;
        sum = 0;
        for (int t = 0; t < 9; t++) sum += act_s(pat, pix, c, t) * sw(c, t);
        cnt = 0;
        for (int j = 0; j < 3; j++) if (sum >= 12*j + 4*c) cnt++;
        ea[p*2 +: 2] = 2'(cnt - 2);
        eb[p*16 +: 16] = 16'(sum);
      end
      qa.push_back(ea);
      qb.push_back(eb);
    end
    for (int n = 0; n < 2; n++) begin
      for (int f = 0; f < 3; f++) begin
        logic [23:0] beat;
        for (int p = 0; p < 2; p++)
          for (int s = 0; s < 3; s++)
            beat[(p*3+s)*4 +: 4] = 4'(act_s(pat, pix, n*2+p, f*3+s));
        send_beat(1'b0, beat);
        if (n == 0 && f == 0) t_first = t_last;
      end
    end
  endtask

  task automatic pixel_b(int pix);
    for (int n = 0; n < 2; n++) begin
      logic [1:0] ec;
      for (int p = 0; p < 2; p++) begin
        int c, dot;
        c = n*2 + p;
        dot = 0;
        for (int t = 0; t < 9; t++) dot += (2*act_b(pix, c, t) - 1) * (2*bwb(c, t) - 1);
        ec[p] = (dot >= 2*c - 3);
      end
      qc.push_back(ec);
    end
    for (int n = 0; n < 2; n++) begin
      for (int f = 0; f < 3; f++) begin
        logic [23:0] beat;
        beat = '0;
        for (int p = 0; p < 2; p++)
          for (int s = 0; s < 3; s++)
            beat[p*3+s] = 1'(act_b(pix, n*2+p, f*3+s));
        send_beat(1'b1, beat);
      end
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk); #2;
    // R1
    chk(!a_ov && !b_ov && !c_ov, "R1", a_ov, 0);
    chk(a_rdy && c_rdy, "R1", a_rdy, 1);

    // R8: all-zero pixel, channel 0 meets its zero threshold
    a_tag = "R8"; b_tag = "R2";
    pixel_s(0, 0); idle(4);
    a_tag = "R7";
    pixel_s(1, 1); idle(4);
    pixel_s(2, 2); idle(4);

    // R5: full rate and result latency
    b_tag = "R3";
    pixel_s(3, 3);
    chk((t_last - t_first) == 5 * 20, "R5", (t_last - t_first) / 20, 5);
    @(negedge clk); s_v = 1'b0; #2;
    chk(a_ov == 1'b0, "R5", a_ov, 0);
    @(negedge clk); #2;
    chk(a_ov == 1'b1, "R5", a_ov, 1);
    idle(3);

    // R4: back-to-back pixels
    b_tag = "R4";
    for (int pix = 4; pix < 20; pix++) pixel_s(3, pix);
    idle(4);

    // R6: output backpressure
    a_tag = "R6"; b_tag = "R6"; bp = 1;
    for (int pix = 20; pix < 30; pix++) pixel_s(3, pix);
    idle(20);
    bp = 0;
    idle(4);

    // R9: bipolar XNOR-popcount with biased thresholds
    for (int pix = 0; pix < 40; pix++) pixel_b(pix);
    idle(6);

    // R3: every expected word arrived
    chk(qa.size() == 0 && qb.size() == 0, "R3", qa.size() + qb.size(), 0);
    chk(qc.size() == 0, "R9", qc.size(), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule